// File: doc/BRIEF.md
# Power-Fail Reset and Pushbutton Debouncer

This block produces an active-low reset request for a shared open-drain reset pin and a matching bus-access enable for the serial register interface. It has two sources of reset. One is a supply-good flag from an analog comparator. The other is a pushbutton that pulls the same pin low. While the supply is bad, reset is driven at once. After the supply recovers, reset is held for a fixed number of slow ticks. A low level on the pin must stay low for a debounce window before it is accepted as a button press. An accepted press then yields a reset pulse of the same hold length.

The slow ticks come from the 32.768 kHz timebase as a one-cycle enable (`tick_en`) on the system clock. The defaults give roughly 183 ms for both windows. When the oscillator had been stopped, its start-up allowance (`OSC_START_TICKS`) is added to the supply-recovery hold. The block senses the pin through a synchronizer. It ignores the low level that its own drive causes, both while it drives and for as long as that drive takes to leave the synchronizer. The serial interface must refuse all register reads and writes while `bus_en` is low.

Top module: `pfr_reset_ctl`

## Requirements
- R1: While `rst_n` is low, `rst_drive_n` and `bus_en` are 0. After `rst_n` is released, reset stays asserted until a complete supply-recovery hold (R3) has elapsed.
- R2: In any cycle where `supply_ok` is 0, `rst_drive_n` and `bus_en` are 0 in that same cycle. Both stay 0 in the following cycle.
- R3: Call c0 the first cycle in which `supply_ok` is 1 while the block is in the supply-fail condition. Reset is released in the cycle after the clock edge that ends the HOLD_TICKS-th cycle with `tick_en`=1, counting from cycle c0+1. A release therefore always follows a cycle with `tick_en`=1.
- R4: If `osc_cold` is 1 in cycle c0, the hold of R3 lasts HOLD_TICKS+OSC_START_TICKS ticks.
- R5: If the supply drops during a hold, the hold is abandoned. A full hold restarts from the next recovery.
- R6: A pin level of 0 on `pin_in` is seen SYNC_STAGES cycles late. Once it has been seen low for DEBOUNCE_TICKS tick cycles in a row, reset is driven. It then stays low for HOLD_TICKS tick cycles, counted from the first cycle it is low.
- R7: If the synchronized pin returns to 1 before the debounce completes, the count restarts from zero. A press shorter than the window produces no reset.
- R8: While the block drives the pin low, and for SYNC_STAGES cycles after it releases the pin, the pin level is not counted. A button still held after a pulse causes the next pulse only after a full debounce, counted from SYNC_STAGES cycles after the release.
- R9: `bus_en` equals `rst_drive_n` in every cycle, so register access stays refused until reset goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz period |
| supply_ok | input | 1 | 1 when the supply is above the fail threshold |
| osc_cold | input | 1 | 1 when the oscillator was stopped and needs start-up time |
| pin_in | input | 1 | Sensed level of the shared reset/pushbutton pin |
| rst_drive_n | output | 1 | 0 = pull the reset pin low |
| bus_en | output | 1 | 1 = register access allowed |

## Verification
The supply monitor and the pushbutton path can act in the same cycle. This happens when a supply drop lands on the tick that would complete a debounce, or when a button is held through a supply-recovery hold. The bench provokes both with randomized supply glitches placed among random-length presses. A cycle-level expectation built from the requirements decides the outcome, with the supply taking precedence. It also checks that a button still held after a hold ends is counted afresh and not carried over.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    ST_FAIL = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2,
    ST_PB   = 2'd3
  } pfr_state_e;
endpackage

// File: rtl/pfr_sync.sv
module pfr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfr_tick_cnt.sv
module pfr_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic [W-1:0] count,
  output logic         hit
);
  assign hit = tick && !clr && (count == target - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (hit)   count <= '0;
    else if (tick)  count <= count + W'(1);
  end
endmodule

// File: rtl/pfr_reset_ctl.sv
module pfr_reset_ctl
  import pfr_pkg::*;
#(
  parameter int HOLD_TICKS      = 6000,
  parameter int DEBOUNCE_TICKS  = 6000,
  parameter int OSC_START_TICKS = 32768,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic supply_ok,
  input  logic osc_cold,
  input  logic pin_in,
  output logic rst_drive_n,
  output logic bus_en
);
  localparam int HW = $clog2(HOLD_TICKS + OSC_START_TICKS + 1);
  localparam int DW = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [HW-1:0] HOLD_N = HW'(HOLD_TICKS);
  localparam logic [HW-1:0] COLD_N = HW'(HOLD_TICKS + OSC_START_TICKS);
  localparam logic [DW-1:0] DB_N   = DW'(DEBOUNCE_TICKS);

  pfr_state_e    state, state_nx;
  logic [HW-1:0] hold_tgt;
  logic [HW-1:0] hold_cnt;
  logic          hold_hit;
  logic [DW-1:0] db_count;
  logic          db_hit;
  logic          pin_s;
  logic          drv_q;
  logic          armed;

  // pin sense and own-drive history share the same latency
  pfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );
  pfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_drv_sync (
    .clk(clk), .rst_n(rst_n), .d(rst_drive_n), .q(drv_q)
  );

  assign armed = (state == ST_RUN) && drv_q;

  pfr_tick_cnt #(.W(HW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .clr((state != ST_HOLD) && (state != ST_PB)),
    .tick(tick_en), .target(hold_tgt),
    .count(hold_cnt), .hit(hold_hit)
  );

  pfr_tick_cnt #(.W(DW)) u_debounce (
    .clk(clk), .rst_n(rst_n),
    .clr(!armed || pin_s),
    .tick(tick_en), .target(DB_N),
    .count(db_count), .hit(db_hit)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FAIL: if (supply_ok) state_nx = ST_HOLD;
      ST_HOLD: if (!supply_ok) state_nx = ST_FAIL;
               else if (hold_hit) state_nx = ST_RUN;
      ST_RUN:  if (!supply_ok) state_nx = ST_FAIL;
               else if (db_hit) state_nx = ST_PB;
      ST_PB:   if (!supply_ok) state_nx = ST_FAIL;
               else if (hold_hit) state_nx = ST_RUN;
      default: state_nx = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FAIL;
      hold_tgt <= HOLD_N;
    end else begin
      state <= state_nx;
      if (state == ST_FAIL && state_nx == ST_HOLD)
        hold_tgt <= osc_cold ? COLD_N : HOLD_N;
      else if (state == ST_RUN && state_nx == ST_PB)
        hold_tgt <= HOLD_N;
    end
  end

  assign rst_drive_n = supply_ok && (state == ST_RUN);
  assign bus_en      = rst_drive_n;
endmodule

// File: rtl/pfr_reset_chk.sv
module pfr_reset_chk
  import pfr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       supply_ok,
  input logic       rst_drive_n,
  input logic       pin_s,
  input logic [1:0] st,
  input logic       db_zero,
  input logic       hold_in_range
);
  // R2
  drop_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !rst_drive_n);

  // R3
  release_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_drive_n) |-> $past(tick_en));

  // R3
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_in_range);

  // R5
  hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !supply_ok) |=> (st == ST_FAIL));

  // R6
  press_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_drive_n) && supply_ok) |-> $past(!pin_s));

  // R8
  blank_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN) |=> db_zero);
endmodule

bind pfr_reset_ctl pfr_reset_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tick_en(tick_en),
  .supply_ok(supply_ok),
  .rst_drive_n(rst_drive_n),
  .pin_s(pin_s),
  .st(state),
  .db_zero(db_count == '0),
  .hold_in_range(hold_cnt < hold_tgt)
);

// File: tb/sim_pfr_reset_ctl.sv
`timescale 1ns/1ps
module sim_pfr_reset_ctl;
  localparam int HOLD = 8;
  localparam int DB   = 5;
  localparam int OSCS = 4;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic supply_ok = 1'b0;
  logic osc_cold = 1'b0;
  logic btn_n = 1'b1;
  logic rst_drive_n, bus_en;
  wire  pin = btn_n & rst_drive_n;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pfr_reset_ctl #(.HOLD_TICKS(HOLD), .DEBOUNCE_TICKS(DB),
                  .OSC_START_TICKS(OSCS), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .supply_ok(supply_ok),
    .osc_cold(osc_cold), .pin_in(pin), .rst_drive_n(rst_drive_n), .bus_en(bus_en)
  );

  // slow tick: one cycle in three
  int tdiv = 0;
  always begin
    @(posedge clk); #2;
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick_en = (tdiv == 2);
  end

  // expectation model: 0 fail, 1 hold, 2 running, 3 button pulse
  int m_st, m_cnt, m_tgt, m_db;
  logic p1, p2, d1, d2;
  wire exp_drv = supply_ok && (m_st == 2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_tgt <= HOLD; m_db <= 0;
      p1 <= 1'b1; p2 <= 1'b1; d1 <= 1'b0; d2 <= 1'b0;
    end else begin
      p1 <= pin; p2 <= p1; d1 <= exp_drv; d2 <= d1;
      case (m_st)
        0: begin
          m_db <= 0; m_cnt <= 0;
          if (supply_ok) begin m_st <= 1; m_tgt <= osc_cold ? HOLD + OSCS : HOLD; end
        end
        1, 3: begin
          if (!supply_ok) begin m_st <= 0; m_cnt <= 0; end
          else if (tick_en) begin
            if (m_cnt + 1 == m_tgt) begin m_st <= 2; m_cnt <= 0; end
            else m_cnt <= m_cnt + 1;
          end
        end
        default: begin
          if (!supply_ok) begin m_st <= 0; m_db <= 0; end
          else if (d2 && !p2) begin
            if (tick_en) begin
              if (m_db + 1 == DB) begin m_st <= 3; m_tgt <= HOLD; m_db <= 0; end
              else m_db <= m_db + 1;
            end
          end else m_db <= 0;
        end
      endcase
    end
  end

  function automatic string phase_tag(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (rst_drive_n !== exp_drv) begin
        errors++;
        $display("FAIL %s cycle compare: rst_drive_n=%b expected %b at %0t",
                 phase_tag(m_st), rst_drive_n, exp_drv, $time);
      end
      checks++;
      if (bus_en !== rst_drive_n) begin
        errors++;
        $display("FAIL R9 bus_en=%b expected %b at %0t", bus_en, rst_drive_n, $time);
      end
    end
  end

  task automatic check_eq(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic drv_step();
    @(posedge clk); #2;
  endtask

  task automatic set_supply(logic v);
    drv_step(); supply_ok = v;
  endtask

  // call right after a supply rise: ticks counted from c0+1 until release
  task automatic measure_hold(string tag, int exp_v);
    int n = 0;
    @(negedge clk);
    for (int g = 0; g < 400; g++) begin
      @(negedge clk);
      if (rst_drive_n) break;
      if (tick_en) n++;
    end
    check_eq(tag, n, exp_v);
  endtask

  // from the current cycle, count ticks while reset stays low
  task automatic measure_low(string tag, int exp_v);
    int n = 0;
    for (int g = 0; g < 400; g++) begin
      if (rst_drive_n) break;
      if (tick_en) n++;
      @(negedge clk);
    end
    check_eq(tag, n, exp_v);
  endtask

  // pin seen low from this negedge on: count ticks until reset falls
  task automatic measure_debounce(string tag, int exp_v);
    int n = 0;
    for (int g = 0; g < 400; g++) begin
      if (!rst_drive_n) break;
      if (tick_en) n++;
      @(negedge clk);
    end
    check_eq(tag, n, exp_v);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd1234);
    seed = seed;
    // R1: system reset
    repeat (4) drv_step();
    supply_ok = 1'b1;
    @(negedge clk);
    check_eq("R1 drive in reset", int'(rst_drive_n), 0);
    check_eq("R1 bus in reset", int'(bus_en), 0);
    supply_ok = 1'b0;
    drv_step(); rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (5) drv_step();
    @(negedge clk);
    check_eq("R1 low after reset", int'(rst_drive_n), 0);

    // R3: plain recovery
    set_supply(1'b1);
    measure_hold("R3 hold ticks", HOLD);

    // R2: one-cycle glitch, same-cycle reaction
    set_supply(1'b0);
    @(negedge clk);
    check_eq("R2 same-cycle drive", int'(rst_drive_n), 0);
    check_eq("R2 same-cycle bus", int'(bus_en), 0);
    set_supply(1'b1);
    measure_hold("R3 hold after glitch", HOLD);

    // R4: cold oscillator lengthens the hold
    set_supply(1'b0);
    drv_step(); osc_cold = 1'b1;
    set_supply(1'b1);
    drv_step(); osc_cold = 1'b0;
    begin
      int n = 0;
      for (int g = 0; g < 400; g++) begin
        @(negedge clk);
        if (rst_drive_n) break;
        if (tick_en) n++;
      end
      check_eq("R4 cold hold ticks", n, HOLD + OSCS);
    end

    // R5: drop during hold restarts
    set_supply(1'b0);
    set_supply(1'b1);
    repeat (12) drv_step();
    set_supply(1'b0);
    set_supply(1'b1);
    measure_hold("R5 restarted hold", HOLD);

    // R6: clean press
    repeat (6) drv_step();
    btn_n = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    measure_debounce("R6 debounce ticks", DB);
    drv_step(); btn_n = 1'b1;
    @(negedge clk);
    measure_low("R6 pulse ticks", HOLD - ((tick_en && 1'b0) ? 1 : 0));

    // R7: short press ignored, bounce restarts count
    repeat (8) drv_step();
    btn_n = 1'b0;
    repeat (8) drv_step();
    btn_n = 1'b1;
    repeat (4) drv_step();
    @(negedge clk);
    check_eq("R7 no reset from bounce", int'(rst_drive_n), 1);
    drv_step(); btn_n = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    measure_debounce("R7 full debounce after bounce", DB);
    measure_low("R6 pulse after bounce", HOLD);

    // R8: button still held through and after the pulse
    @(negedge clk); @(negedge clk);
    measure_debounce("R8 held button re-debounce", DB);
    drv_step(); btn_n = 1'b1;
    @(negedge clk);
    measure_low("R8 second pulse", HOLD);

    // random mix of glitches, presses and cold starts
    for (int i = 0; i < 300; i++) begin
      int act = $urandom_range(0, 9);
      if (act < 2) begin
        osc_cold = 1'($urandom_range(0, 1));
        set_supply(1'b0);
        repeat ($urandom_range(0, 4)) drv_step();
        set_supply(1'b1);
        osc_cold = 1'b0;
      end else if (act < 7) begin
        drv_step(); btn_n = 1'b0;
        repeat ($urandom_range(1, 30)) drv_step();
        btn_n = 1'b1;
      end else begin
        repeat ($urandom_range(1, 40)) drv_step();
      end
    end
    btn_n = 1'b1; supply_ok = 1'b1;
    repeat (80) drv_step();
    @(negedge clk);
    check_eq("R9 final bus state", int'(bus_en), int'(rst_drive_n));

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule